// File: doc/BRIEF.md
# SDRAM Auto-Refresh Request Scheduler

This block decides when an SDRAM controller has to spend a cycle on an auto-refresh. A 16-bit interval register holds a terminal count. An up-counter runs on the memory clock, and when it reaches that count the refresh timer has expired. If the read/write transaction engine is idle at that moment, a refresh request is raised on the next clock. If a transaction is in flight, the request is held back until the engine reports idle. The request is a level that stays high until the command engine acknowledges it. That acknowledge is the moment the refresh is issued.

Issuing a refresh closes every open page. To make that visible, the block carries a four-bank open-page table. Each entry holds a valid bit and the open row. The command engine marks banks open and closed through it, and the controller can look up whether a bank/row pair is a page hit. Every issued refresh clears all valid bits at once. A zero interval turns automatic refresh off. Writing any interval restarts the timer. The counter reloads at issue, not at expiry, so a deferred refresh never shortens the interval that follows.

At a 133 MHz memory clock, the largest count (0xFFFF) spaces refreshes about 492 µs apart. A count of 0x1AB5 gives roughly 51.4 µs.

Top module: `refresh_scheduler`

## Requirements
- R1: After reset the interval register holds 0x0384, `ref_req` is low and all four bits of `pg_valid` are 0.
- R2: With a nonzero interval N and `xact_busy` low, `ref_req` stays low for exactly N+1 clock cycles and then rises. The count starts from reset release, from an interval write, or from an accepted acknowledge.
- R3: If `xact_busy` is high when the timer expires, `ref_req` stays low for as long as `xact_busy` stays high. It rises on the clock edge that samples `xact_busy` low.
- R4: The timer reloads when a refresh is issued (`ref_req` and `ref_ack` high at a clock edge), not when it expires. After a deferred refresh, the next request therefore again comes N+1 idle cycles after the acknowledge.
- R5: `ref_req` stays high until `ref_ack` is sampled high at a clock edge, and it is low in the following cycle. However long the acknowledge is delayed, no second request is queued behind the first.
- R6: While the interval register holds 0, no new refresh request is ever raised.
- R7: A write of `cfg_interval` with `cfg_we` high loads the register and restarts the counter from zero. The following request obeys R2 with the new value.
- R8: An issued refresh clears every `pg_valid` bit on the same clock edge, and a simultaneous page open is overridden. A raised but unacknowledged request leaves the table untouched.
- R9: `pg_open` sets the valid bit of `pg_open_bank` and records `pg_open_row`; `pg_close` clears the valid bit of `pg_close_bank`. `lk_hit` is high, combinationally, exactly when `lk_bank` is valid and its recorded row equals `lk_row`. Bit i of `pg_valid` belongs to bank i.
- R10: An interval write while an expiry is waiting out a busy transaction discards that waiting expiry. The next request then follows R2 from the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Interval register write strobe |
| cfg_interval | input | 16 | New terminal count; 0 disables refresh |
| xact_busy | input | 1 | A read or write transaction is in flight |
| ref_req | output | 1 | Auto-refresh request, held until acknowledged |
| ref_ack | input | 1 | Command engine accepts the refresh |
| pg_open | input | 1 | Mark a bank's page open |
| pg_open_bank | input | 2 | Bank being opened |
| pg_open_row | input | 13 | Row opened in that bank |
| pg_close | input | 1 | Mark a bank's page closed |
| pg_close_bank | input | 2 | Bank being closed |
| lk_bank | input | 2 | Bank of the page-hit lookup |
| lk_row | input | 13 | Row of the page-hit lookup |
| lk_hit | output | 1 | Lookup bank is open on the lookup row |
| pg_valid | output | 4 | Open-page valid bit per bank |

## Verification
The assertions take for granted that `ref_ack` only counts while `ref_req` is high; an acknowledge outside a request is treated as noise and has no effect. They also assume that every input carries a defined level after reset. The bench drives all inputs to known values from time zero and raises `ref_ack` only at a negative edge where it has seen `ref_req` high. It changes `xact_busy` and `cfg_we` away from the active edge, so each deferral and restart lands on a known clock.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    // Phase of the refresh request path.
    typedef enum logic [1:0] {
        RQ_IDLE = 2'd0,   // timer running
        RQ_WAIT = 2'd1,   // expired, held back by a busy transaction
        RQ_OUT  = 2'd2    // request raised, awaiting acknowledge
    } rq_phase_e;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int               CNT_W          = 16,
    parameter logic [CNT_W-1:0] RESET_INTERVAL = 16'h0384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_value,
    input  logic             hold,
    input  logic             restart,
    output logic             expire,
    output logic             enabled
);

    typedef struct packed {
        logic [CNT_W-1:0] interval;
        logic [CNT_W-1:0] count;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (cfg_we) begin
            tmr_d.interval = cfg_value;
            tmr_d.count    = '0;
        end else if (restart) begin
            tmr_d.count = '0;
        end else if (!hold && enabled && (tmr_q.count != tmr_q.interval)) begin
            tmr_d.count = tmr_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.interval <= RESET_INTERVAL;
            tmr_q.count    <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign enabled = (tmr_q.interval != '0);
    assign expire  = enabled && !hold && !cfg_we && (tmr_q.count == tmr_q.interval);

    // R2: the counter never runs past the terminal count.
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.count <= tmr_q.interval);

    // R4: while a refresh is outstanding the count is frozen.
    a_r4_frozen_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !restart && !cfg_we) |=> (tmr_q.count == $past(tmr_q.count)));

endmodule

// File: rtl/ref_request_fsm.sv
module ref_request_fsm
    import refsch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic cfg_we,
    input  logic xact_busy,
    input  logic ref_ack,
    output logic ref_req,
    output logic issue,
    output logic hold
);

    rq_phase_e ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            RQ_IDLE: begin
                if (expire) begin
                    ph_d = xact_busy ? RQ_WAIT : RQ_OUT;
                end
            end
            RQ_WAIT: begin
                if (cfg_we) begin
                    ph_d = RQ_IDLE;
                end else if (!xact_busy) begin
                    ph_d = RQ_OUT;
                end
            end
            RQ_OUT: begin
                if (ref_ack) begin
                    ph_d = RQ_IDLE;
                end
            end
            default: ph_d = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= RQ_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign ref_req = (ph_q == RQ_OUT);
    assign issue   = ref_req && ref_ack;
    assign hold    = (ph_q != RQ_IDLE);

    // R5: a raised request waits for its acknowledge.
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_ack) |=> ref_req);

    // R5: an acknowledged request drops at once.
    a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_ack) |=> !ref_req);

    // R3: a busy transaction keeps the request from rising.
    a_r3_busy_defers: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_req && xact_busy) |=> !ref_req);

endmodule

// File: rtl/ref_page_table.sv
module ref_page_table #(
    parameter int BANKS = 4,
    parameter int ROW_W = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_all,
    input  logic                     open_en,
    input  logic [$clog2(BANKS)-1:0] open_bank,
    input  logic [ROW_W-1:0]         open_row,
    input  logic                     close_en,
    input  logic [$clog2(BANKS)-1:0] close_bank,
    input  logic [$clog2(BANKS)-1:0] lk_bank,
    input  logic [ROW_W-1:0]         lk_row,
    output logic                     lk_hit,
    output logic [BANKS-1:0]         valid
);

    localparam int BANK_W = $clog2(BANKS);

    typedef struct packed {
        logic [BANKS-1:0]            valid;
        logic [BANKS-1:0][ROW_W-1:0] rows;
    } pt_s;

    pt_s pt_d, pt_q;

    logic [BANKS-1:0]            nxt_valid;
    logic [BANKS-1:0][ROW_W-1:0] nxt_rows;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic             v_n;
        logic [ROW_W-1:0] r_n;

        always_comb begin
            v_n = pt_q.valid[b];
            r_n = pt_q.rows[b];
            if (clear_all) begin
                v_n = 1'b0;
            end else if (open_en && (open_bank == BANK_W'(b))) begin
                v_n = 1'b1;
                r_n = open_row;
            end else if (close_en && (close_bank == BANK_W'(b))) begin
                v_n = 1'b0;
            end
        end

        assign nxt_valid[b] = v_n;
        assign nxt_rows[b]  = r_n;
    end

    always_comb begin
        pt_d       = pt_q;
        pt_d.valid = nxt_valid;
        pt_d.rows  = nxt_rows;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pt_q <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    assign valid  = pt_q.valid;
    assign lk_hit = pt_q.valid[lk_bank] && (pt_q.rows[lk_bank] == lk_row);

    // R8: a refresh empties the whole table.
    a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (valid == '0));

    // R9: an open without a refresh marks its bank valid.
    a_r9_open_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (open_en && !clear_all) |=> valid[$past(open_bank)]);

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
    import refsch_pkg::*;
#(
    parameter int               CNT_W          = 16,
    parameter logic [CNT_W-1:0] RESET_INTERVAL = 16'h0384,
    parameter int               BANKS          = 4,
    parameter int               ROW_W          = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CNT_W-1:0]         cfg_interval,
    input  logic                     xact_busy,
    output logic                     ref_req,
    input  logic                     ref_ack,
    input  logic                     pg_open,
    input  logic [$clog2(BANKS)-1:0] pg_open_bank,
    input  logic [ROW_W-1:0]         pg_open_row,
    input  logic                     pg_close,
    input  logic [$clog2(BANKS)-1:0] pg_close_bank,
    input  logic [$clog2(BANKS)-1:0] lk_bank,
    input  logic [ROW_W-1:0]         lk_row,
    output logic                     lk_hit,
    output logic [BANKS-1:0]         pg_valid
);

    logic tmr_expire;
    logic tmr_enabled;
    logic rq_issue;
    logic rq_hold;

    ref_interval_timer #(
        .CNT_W          (CNT_W),
        .RESET_INTERVAL (RESET_INTERVAL)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_value (cfg_interval),
        .hold      (rq_hold),
        .restart   (rq_issue),
        .expire    (tmr_expire),
        .enabled   (tmr_enabled)
    );

    ref_request_fsm u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (tmr_expire),
        .cfg_we    (cfg_we),
        .xact_busy (xact_busy),
        .ref_ack   (ref_ack),
        .ref_req   (ref_req),
        .issue     (rq_issue),
        .hold      (rq_hold)
    );

    ref_page_table #(
        .BANKS (BANKS),
        .ROW_W (ROW_W)
    ) u_pages (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_all  (rq_issue),
        .open_en    (pg_open),
        .open_bank  (pg_open_bank),
        .open_row   (pg_open_row),
        .close_en   (pg_close),
        .close_bank (pg_close_bank),
        .lk_bank    (lk_bank),
        .lk_row     (lk_row),
        .lk_hit     (lk_hit),
        .valid      (pg_valid)
    );

    // R6: with refresh off and nothing outstanding, no request appears.
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_enabled && !ref_req) |=> !ref_req);

    // R8: the acknowledge edge of a refresh closes every page.
    a_r8_pages_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_ack) |=> (pg_valid == '0 && !lk_hit));

endmodule

// File: tb/sim_refresh_scheduler.sv
module sim_refresh_scheduler;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_interval = '0;
    logic        xact_busy = 1'b0;
    logic        ref_req;
    logic        ref_ack = 1'b0;
    logic        pg_open = 1'b0;
    logic [1:0]  pg_open_bank = '0;
    logic [12:0] pg_open_row = '0;
    logic        pg_close = 1'b0;
    logic [1:0]  pg_close_bank = '0;
    logic [1:0]  lk_bank = '0;
    logic [12:0] lk_row = '0;
    logic        lk_hit;
    logic [3:0]  pg_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_scheduler u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_interval  (cfg_interval),
        .xact_busy     (xact_busy),
        .ref_req       (ref_req),
        .ref_ack       (ref_ack),
        .pg_open       (pg_open),
        .pg_open_bank  (pg_open_bank),
        .pg_open_row   (pg_open_row),
        .pg_close      (pg_close),
        .pg_close_bank (pg_close_bank),
        .lk_bank       (lk_bank),
        .lk_row        (lk_row),
        .lk_hit        (lk_hit),
        .pg_valid      (pg_valid)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Count negedge samples with ref_req low, starting at the current one.
    task automatic count_low(output int n);
        n = 0;
        while (!ref_req && n < 70000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic write_interval(input logic [15:0] v);
        cfg_we       = 1'b1;
        cfg_interval = v;
        @(negedge clk);
        cfg_we       = 1'b0;
    endtask

    task automatic do_ack(input string req);
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
        check(ref_req == 1'b0, req, "request drops after ack", int'(ref_req), 0);
    endtask

    task automatic settle();
        if (ref_req) do_ack("R5");
    endtask

    task automatic t_reset_default();
        int n;
        repeat (3) @(negedge clk);
        check(ref_req == 1'b0, "R1", "ref_req in reset", int'(ref_req), 0);
        check(pg_valid == 4'h0, "R1", "pg_valid in reset", int'(pg_valid), 0);
        rst_n = 1'b1;
        count_low(n);
        check(n == 901, "R1", "default interval gap", n, 901);
    endtask

    task automatic t_idle_gaps();
        int n;
        settle();
        write_interval(16'd10);
        count_low(n);
        check(n == 11, "R2", "gap after write of 10", n, 11);
        do_ack("R5");
        count_low(n);
        check(n == 11, "R2", "gap after ack", n, 11);
    endtask

    task automatic t_restart();
        int n;
        settle();
        write_interval(16'd20);
        repeat (10) @(negedge clk);
        write_interval(16'd8);
        count_low(n);
        check(n == 9, "R7", "gap after rewrite to 8", n, 9);
    endtask

    task automatic t_busy_defer();
        int n;
        settle();
        xact_busy = 1'b1;
        write_interval(16'd6);
        n = 0;
        repeat (20) begin
            if (ref_req) n++;
            @(negedge clk);
        end
        check(n == 0, "R3", "request held off while busy", n, 0);
        xact_busy = 1'b0;
        @(negedge clk);
        check(ref_req == 1'b1, "R3", "request one clock after idle", int'(ref_req), 1);
        do_ack("R5");
        count_low(n);
        check(n == 7, "R4", "full gap after deferred refresh", n, 7);
    endtask

    task automatic t_hold_no_queue();
        int n;
        settle();
        write_interval(16'd4);
        count_low(n);
        check(n == 5, "R2", "gap for interval 4", n, 5);
        n = 0;
        repeat (30) begin
            if (!ref_req) n++;
            @(negedge clk);
        end
        check(n == 0, "R5", "request held without ack", n, 0);
        do_ack("R5");
        count_low(n);
        check(n == 5, "R5", "no queued second request", n, 5);
    endtask

    task automatic t_drop_pending();
        int n;
        settle();
        xact_busy = 1'b1;
        write_interval(16'd6);
        repeat (20) @(negedge clk);
        write_interval(16'd6);
        xact_busy = 1'b0;
        count_low(n);
        check(n == 7, "R10", "waiting expiry discarded by write", n, 7);
    endtask

    task automatic t_zero_disable();
        int n;
        settle();
        write_interval(16'd0);
        n = 0;
        repeat (200) begin
            if (ref_req) n++;
            @(negedge clk);
        end
        check(n == 0, "R6", "no request with zero interval", n, 0);
    endtask

    task automatic t_pages();
        int n;
        settle();
        write_interval(16'd0);
        for (int b = 0; b < 4; b++) begin
            pg_open      = 1'b1;
            pg_open_bank = 2'(b);
            pg_open_row  = 13'(100 + b);
            @(negedge clk);
        end
        pg_open = 1'b0;
        check(pg_valid == 4'hF, "R9", "all banks open", int'(pg_valid), 15);
        lk_bank = 2'd1; lk_row = 13'd101; #1;
        check(lk_hit == 1'b1, "R9", "lookup hit bank1", int'(lk_hit), 1);
        lk_row = 13'd102; #1;
        check(lk_hit == 1'b0, "R9", "lookup miss wrong row", int'(lk_hit), 0);
        pg_close = 1'b1; pg_close_bank = 2'd2;
        @(negedge clk);
        pg_close = 1'b0;
        check(pg_valid == 4'b1011, "R9", "bank2 closed", int'(pg_valid), 11);
        write_interval(16'd5);
        count_low(n);
        check(n == 6, "R2", "gap for interval 5", n, 6);
        repeat (3) @(negedge clk);
        check(pg_valid == 4'b1011, "R8", "table kept before ack", int'(pg_valid), 11);
        pg_open = 1'b1; pg_open_bank = 2'd2; pg_open_row = 13'd7;
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0; pg_open = 1'b0;
        check(pg_valid == 4'h0, "R8", "all pages closed by refresh", int'(pg_valid), 0);
        lk_bank = 2'd0; lk_row = 13'd100; #1;
        check(lk_hit == 1'b0, "R8", "lookup misses after refresh", int'(lk_hit), 0);
    endtask

    initial begin
        t_reset_default();
        t_idle_gaps();
        t_restart();
        t_busy_defer();
        t_hold_no_queue();
        t_drop_pending();
        t_zero_disable();
        t_pages();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule